// File: doc/BRIEF.md
# Byte-Parallel Reflected CRC-8 Engine

This block keeps a running 8-bit check value over a stream of bytes and folds in one whole byte on every clock edge where the byte strobe is high. The generator is x^8 + x^5 + x^4 + 1 in reflected form, with constant 0x8C: data enters least significant bit first and the register shifts toward bit 0.

Each update reads a 256-entry update table. The table is indexed by the current check value XORed with the incoming byte. Entry k is the check value a zeroed register reaches after absorbing byte k. The table is not stored. It is computed by a chain of eight unrolled single-bit steps, which gives the same values.

A synchronous clear returns the register to zero between messages, and the register holds its value on idle cycles. To check a message, the receiver feeds in the message and then the transmitted check byte. The register returns to zero exactly when the two agree.

Top module: `crc8_byte_engine`

## Requirements
- R1: While the active-low reset is asserted, the check value output is 0x00.
- R2: One accepted byte has the same effect as eight single-bit steps taken least significant data bit first. In each step, let f be register bit 0 XOR the data bit. When f is 0 the register shifts right with 0 entering bit 7. When f is 1 the register is XORed with 0x18 and then shifts right with 1 entering bit 7.
- R3: On an accepted byte the new check value is T[crc XOR byte], where T[k] is the check value of byte k absorbed from 0x00.
- R4: T[0x00..0x17] equals 00 5E BC E2 61 3F DD 83 C2 9C 7E 20 A3 FD 1F 41 9D C3 21 7F FC A2 40 1E.
- R5: When the byte strobe is low and clear is low, the check value is unchanged at the next edge, whatever the byte input carries.
- R6: When clear is high, the check value is 0x00 after the next edge, even if the byte strobe is high in the same cycle.
- R7: Absorbing a byte equal to the current check value yields 0x00, and absorbing any other byte yields a nonzero value.
- R8: Bytes presented on consecutive cycles are each absorbed with no idle cycle between them. Each result appears after the edge that accepts the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clearReq | input | 1 | Synchronous clear of the check value |
| byteValid | input | 1 | Byte strobe; the byte is absorbed at this edge |
| byteIn | input | 8 | Incoming data byte |
| crcOut | output | 8 | Current check value |

## Verification
The bench sweeps all 256 byte values from a cleared register. It compares each result with a bit-serial model and compares the first 24 results with literal table values. A reversed bit order or a wrong constant in any step would show up as a mismatch on a single-bit byte. Clear is driven together with a live strobe, so a design that gives the strobe priority leaves a nonzero value where zero is expected. Random multi-byte streams mix in idle cycles that carry junk bytes and feed back the running check byte. A design that absorbs idle bytes drifts from the model, and one that misindexes the table fails the zero-residue check.

// File: rtl/crc8_pkg.sv
package crc8_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic clear;
  } crcCtrl_t;

endpackage

// File: rtl/crc8_control.sv
module crc8_control
  import crc8_pkg::*;
(
  input  logic     clearReq,
  input  logic     byteValid,
  output crcCtrl_t ctrl
);

  // Clear wins over an accepted byte in the same cycle
  always_comb begin
    ctrl.clear = clearReq;
    ctrl.load  = byteValid & ~clearReq;
  end

endmodule

// File: rtl/crc8_datapath.sv
module crc8_datapath
  import crc8_pkg::*;
#(
  parameter int              CRC_W  = 8,
  parameter int              DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY  = 8'h8C
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcCtrl_t          ctrl,
  input  logic [DATA_W-1:0] byteIn,
  output logic [CRC_W-1:0]  crcQ
);

  localparam int STEPS = DATA_W;

  logic [CRC_W-1:0] stage [0:STEPS];
  logic [CRC_W-1:0] crcNext;

  // Table index: current value folded with the byte
  assign stage[0] = crcQ ^ CRC_W'(byteIn);

  // Table entry computed as an unrolled chain of reflected bit steps
  for (genvar i = 0; i < STEPS; i++) begin : g_step
    assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ POLY)
                                    :  (stage[i] >> 1);
  end

  assign crcNext = stage[STEPS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          crcQ <= '0;
    else if (ctrl.clear) crcQ <= '0;
    else if (ctrl.load)  crcQ <= crcNext;
  end

endmodule

// File: rtl/crc8_byte_engine.sv
module crc8_byte_engine
  import crc8_pkg::*;
#(
  parameter int CRC_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearReq,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteIn,
  output logic [CRC_W-1:0]  crcOut
);

  crcCtrl_t ctrl;

  crc8_control ctrl_i (
    .clearReq  (clearReq),
    .byteValid (byteValid),
    .ctrl      (ctrl)
  );

  crc8_datapath #(
    .CRC_W  (CRC_W),
    .DATA_W (DATA_W),
    .POLY   (CRC_W'(8'h8C))
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .byteIn (byteIn),
    .crcQ   (crcOut)
  );

endmodule

// File: rtl/crc8_engine_chk.sv
module crc8_engine_chk #(
  parameter int CRC_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              clearReq,
  input logic              byteValid,
  input logic [DATA_W-1:0] byteIn,
  input logic [CRC_W-1:0]  crcOut
);

  // R6: clear forces zero and beats the strobe
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (crcOut == '0));

  // R5: idle cycles leave the value untouched
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!clearReq && !byteValid) |=> $stable(crcOut));

  // R7: matching byte gives zero residue
  a_r7_zero_residue: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !clearReq && (CRC_W'(byteIn) == crcOut)) |=> (crcOut == '0));

  // R7: any other byte leaves a nonzero value
  a_r7_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !clearReq && (CRC_W'(byteIn) != crcOut)) |=> (crcOut != '0));

  // R1: output zero while reset is held at a clock edge
  always @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_zero: assert (crcOut == '0);
    end
  end

endmodule

bind crc8_byte_engine crc8_engine_chk #(
  .CRC_W  (CRC_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .clearReq  (clearReq),
  .byteValid (byteValid),
  .byteIn    (byteIn),
  .crcOut    (crcOut)
);

// File: tb/crc8_byte_engine_tb_top.sv
module crc8_byte_engine_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clearReq = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic [7:0] crcOut;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [7:0] modelCrc = 8'h00;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } expItem_t;

  expItem_t sbQ[$];

  localparam logic [7:0] KNOWN [0:23] = '{
    8'h00, 8'h5E, 8'hBC, 8'hE2, 8'h61, 8'h3F, 8'hDD, 8'h83,
    8'hC2, 8'h9C, 8'h7E, 8'h20, 8'hA3, 8'hFD, 8'h1F, 8'h41,
    8'h9D, 8'hC3, 8'h21, 8'h7F, 8'hFC, 8'hA2, 8'h40, 8'h1E};

  always #5 clk = ~clk;

  crc8_byte_engine dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .clearReq  (clearReq),
    .byteValid (byteValid),
    .byteIn    (byteIn),
    .crcOut    (crcOut)
  );

  // Bit-serial reference: XOR with 0x18 then shift in a one (R2)
  function automatic logic [7:0] serialByte(logic [7:0] c, logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = ((c ^ 8'h18) >> 1) | 8'h80;
      else             c = c >> 1;
    end
    return c;
  endfunction

  // Driver: apply one cycle of stimulus, queue the expected result
  task automatic drive(input logic clr, input logic vld, input logic [7:0] b,
                       input string tag, input bit useLit = 0,
                       input logic [7:0] lit = 8'h00);
    expItem_t it;
    clearReq  = clr;
    byteValid = vld;
    byteIn    = b;
    @(posedge clk);
    if (clr)      modelCrc = 8'h00;
    else if (vld) modelCrc = serialByte(modelCrc, b);
    it.exp = useLit ? lit : modelCrc;
    it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compare at falling edges, away from the update edge
  always @(negedge clk) begin
    while (sbQ.size() > 0) begin
      expItem_t it;
      it = sbQ.pop_front();
      checkCnt++;
      if (crcOut !== it.exp) begin
        failCnt++;
        $display("FAIL %s: crcOut=%02h expected=%02h", it.tag, crcOut, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    expItem_t it;
    logic [7:0] junk;
    process::self().srandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R1: reset value
    checkCnt++;
    if (crcOut !== 8'h00) begin
      failCnt++;
      $display("FAIL R1: crcOut=%02h expected=00", crcOut);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R3/R4/R6: sweep every byte from a cleared register
    for (int v = 0; v < 256; v++) begin
      drive(1'b1, 1'b1, 8'(v ^ 8'hA5), "R6 clear beats strobe");
      if (v < 24) drive(1'b0, 1'b1, 8'(v), "R4 table literal", 1'b1, KNOWN[v]);
      else        drive(1'b0, 1'b1, 8'(v), "R3 table from zero");
    end

    // R5: idle cycles with junk on the byte input
    drive(1'b0, 1'b1, 8'h3C, "R8 load before idle");
    for (int k = 0; k < 8; k++) drive(1'b0, 1'b0, 8'($urandom), "R5 idle hold");

    // R2/R8: back-to-back random streams with sparse idles and clears
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      junk = 8'($urandom);
      if (r < 2)       drive(1'b1, 1'($urandom), junk, "R6 random clear");
      else if (r < 12) drive(1'b0, 1'b0, junk, "R5 random idle");
      else             drive(1'b0, 1'b1, junk, "R2 serial match");
    end

    // R7: feed each running check byte back in
    for (int m = 0; m < 20; m++) begin
      drive(1'b1, 1'b0, 8'h00, "R6 clear");
      for (int k = 0; k < 1 + m; k++) drive(1'b0, 1'b1, 8'($urandom), "R8 message byte");
      drive(1'b0, 1'b1, modelCrc, "R7 zero residue");
    end

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule